// File: doc/BRIEF.md
# Power-Pulsed Acquisition Cycle Sequencer

This controller drives one detector front-end channel through a beam cycle that repeats, with a long quiet gap and a short burst of activity. The channel spends most of the cycle unpowered. A wake request, or the end of a programmable idle interval, brings up the front-end supply. After a programmable settle interval the block waits for the bunch-train start marker and then holds an acquisition window open. During that window the analog side stores events into memory cells.

When the bunch-train end marker arrives, or the acquisition budget runs out, the block samples the number of filled cells. It then asks the converter to digitise those cells one at a time, in ascending cell order, and waits for a completion pulse after each request. After the last cell, or when the conversion budget expires, it powers the readout link for a fixed readout window. It then drops every supply and returns to idle.

Every phase duration is a tick count loaded from a configuration input. Full-length beam timing and short test timing therefore run on the same logic. At the 20 MHz system tick, the default 24-bit counters cover the roughly 198 ms quiet gap.

Top module: `pp_cycle_seq`

## Requirements
- R1: While reset is active and after it is released, `phase` is 0 (idle), `pwr_en`, `adc_start`, `ro_req` and `conv_err` are 0 and `adc_cell` is 0. The first idle period after reset lasts the full timer span (2^TIMER_W cycles) unless `wake_req` arrives first.
- R2: Idle moves to wake-up at the first rising edge where `wake_req` is high. Without a request, idle lasts `cfg_idle_ticks`+1 cycles.
- R3: `phase` encodes idle=0, wake-up=1, acquisition=2, conversion=3, readout=4. Each change of phase goes to the next phase in that order, wrapping from readout to idle. The only exception is acquisition going straight to readout.
- R4: `pwr_en` bit 0 (front-end) is high in wake-up, acquisition and conversion. Bit 1 (converter) is high only in conversion. Bit 2 (link) is high only in readout. All bits are 0 in idle.
- R5: In wake-up, `train_start` is ignored during the first `cfg_settle_ticks` cycles. From cycle index `cfg_settle_ticks` on, a high `train_start` moves the block to acquisition at that edge. With `train_start` held high, wake-up therefore lasts `cfg_settle_ticks`+1 cycles.
- R6: Acquisition ends at the edge where `train_end` is high, or after `cfg_acq_ticks`+1 cycles. At that edge `stored_cnt` is sampled and clamped to MAX_EVENTS (16).
- R7: If the sampled count is 0, the block goes directly from acquisition to readout and issues no conversion request.
- R8: In conversion with N cells, `adc_start` pulses for one cycle with `adc_cell` = 0, 1, … N-1 in that order. The first pulse comes in the first conversion cycle. Each later pulse comes in the cycle after the `adc_done` of the previous cell. With a fixed converter latency of L cycles, a full conversion occupies N·(L+1)+1 cycles.
- R9: One cycle after the `adc_done` of the last cell, the block leaves conversion for readout, even if that cycle is also the timeout cycle.
- R10: If conversion lasts `cfg_conv_ticks`+1 cycles without finishing, `conv_err` goes high, the block enters readout, and no further request is issued. `conv_err` stays high until the next entry into wake-up, where it clears.
- R11: Readout holds `ro_req` high, lasts `cfg_ro_ticks`+1 cycles, and then returns to idle.
- R12: An `adc_done` pulse outside a pending conversion request, for example during acquisition, has no effect on the cells requested later or on their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz system tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_req | input | 1 | Leave idle early |
| train_start | input | 1 | Bunch-train start marker |
| train_end | input | 1 | Bunch-train end marker |
| stored_cnt | input | CNT_W (5) | Number of cells filled during the train |
| adc_done | input | 1 | Converter finished the requested cell |
| cfg_idle_ticks | input | TIMER_W (24) | Idle duration minus one |
| cfg_settle_ticks | input | TIMER_W (24) | Wake-up settle count |
| cfg_acq_ticks | input | TIMER_W (24) | Acquisition budget minus one |
| cfg_conv_ticks | input | TIMER_W (24) | Conversion budget minus one |
| cfg_ro_ticks | input | TIMER_W (24) | Readout duration minus one |
| phase | output | 3 | Current phase code (R3) |
| pwr_en | output | 3 | Per-domain power enables (R4) |
| adc_start | output | 1 | One-cycle conversion request |
| adc_cell | output | CELL_W (4) | Cell index for the request |
| ro_req | output | 1 | Readout window active |
| conv_err | output | 1 | Conversion budget expired |

The converter handshake is the only place where the block can be held back. `adc_start` acts as a one-cycle valid, and `adc_done` is the ready for the next cell. No new request is issued until the completion pulse arrives, so a slow converter stretches the conversion phase, up to its budget. All other pins are plain control levels.

## Verification
On every cycle, the embedded properties check:
- the power map against the phase register;
- that phase changes follow the legal order;
- that requests occur only in conversion, last one cycle and carry an index below the sampled count;
- that the error flag rises only on a conversion-to-readout step;
- that the shared timer never counts up without a reload.

Some behaviour can only be shown by the bench scenarios, each pass of which varies settle time, cell count, converter latency and budget:
- the exact length of each phase;
- the clamp on an oversized count;
- the skip on zero cells;
- the ascending cell order;
- completion winning over a simultaneous timeout;
- early markers being ignored.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WAKE = 3'd1,
    PH_ACQ  = 3'd2,
    PH_CONV = 3'd3,
    PH_RO   = 3'd4
  } phase_e;

  localparam int unsigned NUM_DOM  = 3;
  localparam int unsigned DOM_FE   = 0;
  localparam int unsigned DOM_ADC  = 1;
  localparam int unsigned DOM_LINK = 2;

  // Successor in the nominal cycle order.
  function automatic phase_e phase_after(phase_e p);
    case (p)
      PH_IDLE: return PH_WAKE;
      PH_WAKE: return PH_ACQ;
      PH_ACQ:  return PH_CONV;
      PH_CONV: return PH_RO;
      default: return PH_IDLE;
    endcase
  endfunction

  // Whether supply domain d is on in phase p.
  function automatic logic domain_on(int unsigned d, phase_e p);
    case (d)
      DOM_FE:  return (p == PH_WAKE) || (p == PH_ACQ) || (p == PH_CONV);
      DOM_ADC: return (p == PH_CONV);
      default: return (p == PH_RO);
    endcase
  endfunction

endpackage

// File: rtl/pps_phase_timer.sv
`timescale 1ns/1ps
module pps_phase_timer #(
  parameter int TIMER_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [TIMER_W-1:0] load_val_i,
  output logic               zero_o
);

  localparam logic [TIMER_W-1:0] SPAN = '1;

  logic [TIMER_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= SPAN;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R2
  timer_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_i) |-> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/pps_conv_walker.sv
`timescale 1ns/1ps
module pps_conv_walker #(
  parameter int MAX_EVENTS = 16,
  parameter int CNT_W      = $clog2(MAX_EVENTS + 1),
  parameter int CELL_W     = $clog2(MAX_EVENTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  total_i,
  input  logic              stay_i,
  input  logic              done_i,
  output logic              start_o,
  output logic [CELL_W-1:0] cell_o,
  output logic              fin_o
);

  logic [CNT_W-1:0]  total_q;
  logic [CELL_W-1:0] cell_q;
  logic              start_q;
  logic              wait_q;
  logic              fin_q;
  logic              last_cell;

  assign last_cell = ((CNT_W'(cell_q) + 1'b1) == total_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      cell_q  <= '0;
      start_q <= 1'b0;
      wait_q  <= 1'b0;
      fin_q   <= 1'b0;
    end else if (load_i) begin
      total_q <= total_i;
      cell_q  <= '0;
      start_q <= 1'b1;
      wait_q  <= 1'b0;
      fin_q   <= 1'b0;
    end else if (!stay_i) begin
      total_q <= '0;
      cell_q  <= '0;
      start_q <= 1'b0;
      wait_q  <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (start_q) begin
        wait_q <= 1'b1;
      end else if (wait_q && done_i) begin
        wait_q <= 1'b0;
        if (last_cell) begin
          fin_q <= 1'b1;
        end else begin
          cell_q  <= cell_q + 1'b1;
          start_q <= 1'b1;
        end
      end
    end
  end

  assign start_o = start_q;
  assign cell_o  = cell_q;
  assign fin_o   = fin_q;

  // R8
  cell_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (CNT_W'(cell_q) < total_q));

  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R9
  no_start_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> !start_q);

endmodule

// File: rtl/pps_power_map.sv
`timescale 1ns/1ps
module pps_power_map
  import pps_pkg::*;
#(
  parameter int NDOM = NUM_DOM
) (
  input  phase_e          phase_i,
  output logic [NDOM-1:0] en_o
);

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    assign en_o[d] = domain_on(d, phase_i);
  end

endmodule

// File: rtl/pp_cycle_seq.sv
`timescale 1ns/1ps
module pp_cycle_seq
  import pps_pkg::*;
#(
  parameter int MAX_EVENTS = 16,
  parameter int TIMER_W    = 24,
  parameter int CNT_W      = $clog2(MAX_EVENTS + 1),
  parameter int CELL_W     = $clog2(MAX_EVENTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wake_req,
  input  logic               train_start,
  input  logic               train_end,
  input  logic [CNT_W-1:0]   stored_cnt,
  input  logic               adc_done,
  input  logic [TIMER_W-1:0] cfg_idle_ticks,
  input  logic [TIMER_W-1:0] cfg_settle_ticks,
  input  logic [TIMER_W-1:0] cfg_acq_ticks,
  input  logic [TIMER_W-1:0] cfg_conv_ticks,
  input  logic [TIMER_W-1:0] cfg_ro_ticks,
  output logic [2:0]         phase,
  output logic [2:0]         pwr_en,
  output logic               adc_start,
  output logic [CELL_W-1:0]  adc_cell,
  output logic               ro_req,
  output logic               conv_err
);

  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_EVENTS);

  phase_e             phase_q, phase_d;
  logic               err_q;
  logic               err_set, err_clr;
  logic               tmr_load, tmr_zero;
  logic [TIMER_W-1:0] tmr_val;
  logic               walk_load, walk_fin;
  logic [CNT_W-1:0]   events_cap;

  assign events_cap = (stored_cnt > CNT_CAP) ? CNT_CAP : stored_cnt;

  always_comb begin
    phase_d   = phase_q;
    tmr_load  = 1'b0;
    tmr_val   = cfg_idle_ticks;
    walk_load = 1'b0;
    err_set   = 1'b0;
    err_clr   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (wake_req || tmr_zero) begin
          phase_d  = PH_WAKE;
          tmr_load = 1'b1;
          tmr_val  = cfg_settle_ticks;
          err_clr  = 1'b1;
        end
      end
      PH_WAKE: begin
        if (tmr_zero && train_start) begin
          phase_d  = PH_ACQ;
          tmr_load = 1'b1;
          tmr_val  = cfg_acq_ticks;
        end
      end
      PH_ACQ: begin
        if (train_end || tmr_zero) begin
          tmr_load = 1'b1;
          if (events_cap == '0) begin
            phase_d = PH_RO;
            tmr_val = cfg_ro_ticks;
          end else begin
            phase_d   = PH_CONV;
            tmr_val   = cfg_conv_ticks;
            walk_load = 1'b1;
          end
        end
      end
      PH_CONV: begin
        if (walk_fin) begin
          phase_d  = PH_RO;
          tmr_load = 1'b1;
          tmr_val  = cfg_ro_ticks;
        end else if (tmr_zero) begin
          phase_d  = PH_RO;
          tmr_load = 1'b1;
          tmr_val  = cfg_ro_ticks;
          err_set  = 1'b1;
        end
      end
      PH_RO: begin
        if (tmr_zero) begin
          phase_d  = PH_IDLE;
          tmr_load = 1'b1;
          tmr_val  = cfg_idle_ticks;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (err_clr) begin
        err_q <= 1'b0;
      end else if (err_set) begin
        err_q <= 1'b1;
      end
    end
  end

  pps_phase_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  pps_conv_walker #(
    .MAX_EVENTS (MAX_EVENTS),
    .CNT_W      (CNT_W),
    .CELL_W     (CELL_W)
  ) u_walker (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (walk_load),
    .total_i (events_cap),
    .stay_i  (phase_d == PH_CONV),
    .done_i  (adc_done),
    .start_o (adc_start),
    .cell_o  (adc_cell),
    .fin_o   (walk_fin)
  );

  pps_power_map #(.NDOM(NUM_DOM)) u_power (
    .phase_i (phase_q),
    .en_o    (pwr_en)
  );

  assign phase    = phase_q;
  assign ro_req   = (phase_q == PH_RO);
  assign conv_err = err_q;

  // R4
  idle_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> (pwr_en == '0));

  // R4
  converter_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en[DOM_ADC] |-> pwr_en[DOM_FE]);

  // R3
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |->
      ((phase_q == phase_after($past(phase_q))) ||
       (($past(phase_q) == PH_ACQ) && (phase_q == PH_RO))));

  // R8
  request_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (phase_q == PH_CONV));

  // R10
  err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (($past(phase_q) == PH_CONV) && (phase_q == PH_RO)));

endmodule

// File: tb/tb_pp_cycle_seq.sv
`timescale 1ns/1ps
module tb_pp_cycle_seq;

  localparam int MAXE = 16;
  localparam int TW   = 24;
  localparam int CW   = 5;
  localparam int LW   = 4;
  localparam int RO_T = 5;

  // Scenario table: settle, stored, latency (0 = never), conv budget,
  // expected starts, expected error, expected conversion cycles.
  localparam int NV = 8;
  localparam int T_SET [NV] = '{3, 0, 5, 2, 1, 2, 2, 2};
  localparam int T_STO [NV] = '{4, 1, 16, 20, 0, 8, 2, 2};
  localparam int T_LAT [NV] = '{2, 1, 3, 1, 1, 0, 1, 1};
  localparam int T_CTO [NV] = '{200, 200, 500, 500, 50, 30, 4, 3};
  localparam int T_NST [NV] = '{4, 1, 16, 16, 0, 1, 2, 2};
  localparam int T_ERR [NV] = '{0, 0, 0, 0, 0, 1, 0, 1};
  localparam int T_CCY [NV] = '{13, 3, 65, 33, 0, 31, 5, 4};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wake_req = 1'b0;
  logic          train_start = 1'b0;
  logic          train_end = 1'b0;
  logic [CW-1:0] stored_cnt = '0;
  logic          adc_done;
  logic [TW-1:0] cfg_idle = 24'd7;
  logic [TW-1:0] cfg_settle = '0;
  logic [TW-1:0] cfg_acq = 24'd1000;
  logic [TW-1:0] cfg_conv = 24'd100;
  logic [TW-1:0] cfg_ro = TW'(RO_T);
  logic [2:0]    phase;
  logic [2:0]    pwr_en;
  logic          adc_start;
  logic [LW-1:0] adc_cell;
  logic          ro_req;
  logic          conv_err;

  logic mdl_done = 1'b0;
  logic spur_done = 1'b0;
  assign adc_done = mdl_done | spur_done;

  pp_cycle_seq #(.MAX_EVENTS(MAXE), .TIMER_W(TW)) dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .wake_req         (wake_req),
    .train_start      (train_start),
    .train_end        (train_end),
    .stored_cnt       (stored_cnt),
    .adc_done         (adc_done),
    .cfg_idle_ticks   (cfg_idle),
    .cfg_settle_ticks (cfg_settle),
    .cfg_acq_ticks    (cfg_acq),
    .cfg_conv_ticks   (cfg_conv),
    .cfg_ro_ticks     (cfg_ro),
    .phase            (phase),
    .pwr_en           (pwr_en),
    .adc_start        (adc_start),
    .adc_cell         (adc_cell),
    .ro_req           (ro_req),
    .conv_err         (conv_err)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int cnt;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Converter model: answers each request after lat cycles.
  int lat = 1;
  int dly = 0;
  int starts = 0;
  int exp_cell = 0;
  int cell_bad = 0;

  always @(negedge clk) begin
    mdl_done <= 1'b0;
    if (adc_start) begin
      if (int'(adc_cell) != exp_cell) cell_bad++;
      exp_cell++;
      starts++;
      dly = lat;
    end else if (dly > 0) begin
      dly--;
      if (dly == 0) mdl_done <= 1'b1;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 phase in reset", int'(phase), 0);
    chk("R1 pwr in reset", int'(pwr_en), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 idle holds after reset", int'(phase), 0);
    chk("R1 adc_start", int'(adc_start), 0);
    chk("R1 adc_cell", int'(adc_cell), 0);
    chk("R1 ro_req", int'(ro_req), 0);
    chk("R1 conv_err", int'(conv_err), 0);

    for (int i = 0; i < NV; i++) begin
      cfg_settle = TW'(T_SET[i]);
      cfg_conv   = TW'(T_CTO[i]);
      lat = T_LAT[i];
      starts = 0; exp_cell = 0; cell_bad = 0; dly = 0;

      wake_req = 1'b1;
      @(negedge clk);
      wake_req = 1'b0;
      chk("R2 wake on request", int'(phase), 1);
      chk("R4 pwr in wake", int'(pwr_en), 1);

      train_start = 1'b1;
      cnt = 0;
      while (phase == 3'd1 && cnt < 100) begin
        cnt++;
        @(negedge clk);
      end
      train_start = 1'b0;
      chk("R5 settle length", cnt, T_SET[i] + 1);
      chk("R3 acquisition code", int'(phase), 2);
      chk("R4 pwr in acq", int'(pwr_en), 1);

      // R12 stray completion during acquisition
      spur_done = 1'b1;
      @(negedge clk);
      spur_done = 1'b0;
      @(negedge clk);

      stored_cnt = CW'(T_STO[i]);
      train_end = 1'b1;
      @(negedge clk);
      train_end = 1'b0;
      stored_cnt = '0;

      cnt = 0;
      while (phase == 3'd3 && cnt < 1000) begin
        if (cnt == 0) chk("R4 pwr in conv", int'(pwr_en), 3);
        cnt++;
        @(negedge clk);
      end
      chk("R7 R8 R9 R10 conversion cycles", cnt, T_CCY[i]);
      chk("R11 readout entered", int'(phase), 4);
      chk("R6 R7 R8 request count", starts, T_NST[i]);
      chk("R8 R12 cell order", cell_bad, 0);
      chk("R10 error flag", int'(conv_err), T_ERR[i]);
      chk("R4 pwr in readout", int'(pwr_en), 4);
      chk("R11 ro_req", int'(ro_req), 1);

      cnt = 0;
      while (phase == 3'd4 && cnt < 100) begin
        cnt++;
        @(negedge clk);
      end
      chk("R11 readout length", cnt, RO_T + 1);
      chk("R11 back to idle", int'(phase), 0);
      chk("R4 pwr in idle", int'(pwr_en), 0);
      chk("R10 error held", int'(conv_err), T_ERR[i]);
    end

    // R2 idle timeout without request
    cnt = 0;
    while (phase == 3'd0 && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk("R2 idle length", cnt, 8);
    chk("R2 wake after idle", int'(phase), 1);
    chk("R10 error cleared on wake", int'(conv_err), 0);

    // R5 early train_start ignored (settle = 2 loaded)
    train_start = 1'b1;
    @(negedge clk);
    train_start = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 early start ignored", int'(phase), 1);

    // R6 acquisition budget, R7 zero cells
    cfg_acq = 24'd5;
    starts = 0;
    train_start = 1'b1;
    @(negedge clk);
    train_start = 1'b0;
    cnt = 0;
    while (phase == 3'd2 && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk("R6 acquisition timeout length", cnt, 6);
    chk("R7 zero cells skip to readout", int'(phase), 4);
    chk("R7 no request", starts, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule